// File: doc/BRIEF.md
# Serial command frame receiver

This block takes command frames from a host over a three-wire serial link: a serial clock, a data line and a strobe that frames the transfer. While the strobe is high, each rising edge of the serial clock shifts one data bit into a 64-bit frame, least significant bit first. When the strobe drops, a frame of exactly 64 bits is checked and decoded. A frame with any other length is dropped without effect. The three serial inputs are asynchronous to the system clock. They are brought into the system clock domain by synchronizer stages, and their edges are detected there.

A frame counts as good when its eight bytes add to zero modulo 256. The last byte is the padding that makes the sum zero. A 3-bit header in the top of the first byte chooses one of two field maps. The initialisation map fills a bank of set-up parameters: two wait times, a chopping code, an oscillator select, a monitor-select mask and the current references. The run-time map fills the pending parameters of two motor channels: direction, enable, pulse count, step period and current-set select. The low nibble of the first byte drives four open-drain monitor controls in both maps. A checksum-status flag records whether the last complete frame summed correctly. A rejected frame produces a one-cycle error pulse and leaves the banks unchanged.

Top module: `serial_cmd_rx`

## Requirements
- R1: Bits arrive least significant first. The first bit after the strobe rises is bit 0 of byte 1, and the 64th bit is bit 7 of byte 8.
- R2: Data is captured on rising edges of the serial clock only, and only while the strobe is high. Serial clock activity while the strobe is low changes no output.
- R3: A frame is good only when the modulo-256 sum of its eight bytes is 00h.
- R4: After each complete 64-bit frame, csum_ok becomes 1 if the sum is good and 0 if it is not. It changes at no other time.
- R5: Header byte1[7:5] = 3'b111 selects the initialisation map and 3'b000 selects the run-time map. Any other header rejects the frame, even when the sum is good.
- R6: When the strobe falls after fewer or more than 64 serial clocks, the frame is discarded. Every output, including csum_ok, stays as it was, and no error pulse is produced.
- R7: An accepted frame of either type loads byte1[3:0] into mon_release (1 = released, 0 = sinking). A rejected frame leaves mon_release unchanged.
- R8: A bad sum or an illegal header leaves both banks and mon_release unchanged and raises frame_err for exactly one clock.
- R9: The initialisation map sets these outputs:
  - init_start_wait = byte2
  - init_drive_wait = byte3
  - init_chop_code = byte4[4:0]
  - init_osc_internal = byte4[7]
  - init_mon_sel = byte5[6:0]
  - init_iref_a = byte6 (low nibble is reference 1, high nibble is reference 2)
  - init_iref_b = byte7 (same nibble layout)
- R10: The run-time map sets channel alpha as follows:
  - a_dir = byte2[7]
  - a_en = byte2[6]
  - a_pulses = byte2[5:0]
  - a_period = {byte4[6:0], byte3}
  - a_iset = byte4[7]
- R11: The run-time map sets channel beta as follows:
  - b_dir = byte5[7]
  - b_en = byte5[6]
  - b_pulses = byte5[5:0]
  - b_period = {byte7[6:0], byte6}
  - b_iset = byte7[7]
- R12: After reset, both banks are zero, mon_release is 4'hF, csum_ok is 1 and frame_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_strobe | input | 1 | Frame strobe; high while a frame is shifted |
| mon_release | output | 4 | Monitor controls, 1 = released, 0 = sink |
| csum_ok | output | 1 | Sum status of the last complete frame |
| frame_err | output | 1 | One-cycle pulse on a rejected frame |
| init_start_wait | output | 8 | Start wait setting |
| init_drive_wait | output | 8 | Drive wait setting |
| init_chop_code | output | 5 | Chopping frequency code |
| init_osc_internal | output | 1 | Oscillator select, 1 = internal |
| init_mon_sel | output | 7 | Monitor-select mask |
| init_iref_a | output | 8 | Channel alpha current references |
| init_iref_b | output | 8 | Channel beta current references |
| a_dir | output | 1 | Alpha direction |
| a_en | output | 1 | Alpha enable |
| a_pulses | output | 6 | Alpha pulse count code |
| a_period | output | 15 | Alpha step period |
| a_iset | output | 1 | Alpha current-set select |
| b_dir | output | 1 | Beta direction |
| b_en | output | 1 | Beta enable |
| b_pulses | output | 6 | Beta pulse count code |
| b_period | output | 15 | Beta step period |
| b_iset | output | 1 | Beta current-set select |

## Verification
The assertions check on every cycle that:
- the shift register holds still while the strobe is low;
- the checksum flag, the monitor controls and each bank change only in the cycle after a load or a completed frame;
- the accept, run and reject decisions are mutually exclusive;
- the error flag is always a single-cycle pulse that never coincides with a bank change.

Only the bench's scenarios can show the rest:
- that the bit order and the byte-to-field mapping are right;
- that frames of 63 and 65 bits leave everything untouched;
- that data changing while the serial clock is high is not captured;
- that a good sum with an illegal header is rejected while csum_ok stays high.

// File: rtl/serial_cmd_rx_pkg.sv
package serial_cmd_rx_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 8;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
  localparam int HDR_W       = 3;
  localparam logic [HDR_W-1:0] HDR_INIT = 3'b111;
  localparam logic [HDR_W-1:0] HDR_RUN  = 3'b000;
  localparam int MON_W    = 4;
  localparam int CHOP_W   = 5;
  localparam int MSEL_W   = 7;
  localparam int PULSE_W  = 6;
  localparam int PERIOD_W = 15;

  typedef struct packed {
    logic [BYTE_W-1:0] start_wait;
    logic [BYTE_W-1:0] drive_wait;
    logic [CHOP_W-1:0] chop_code;
    logic              osc_internal;
    logic [MSEL_W-1:0] mon_sel;
    logic [BYTE_W-1:0] iref_a;
    logic [BYTE_W-1:0] iref_b;
  } init_cfg_t;

  typedef struct packed {
    logic                dir;
    logic                en;
    logic [PULSE_W-1:0]  pulses;
    logic [PERIOD_W-1:0] period;
    logic                iset;
  } chan_cfg_t;
endpackage

// File: rtl/serial_cmd_rx_sync.sv
module serial_cmd_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], async_in};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl = pipe_q[STAGES-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~prev_q[i];
    assign fall[i] = ~lvl[i] & prev_q[i];
  end
endmodule

// File: rtl/serial_cmd_rx_shift.sv
module serial_cmd_rx_shift #(
  parameter int FRAME_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_rise,
  input  logic                  sdata_lvl,
  input  logic                  strobe_lvl,
  input  logic                  strobe_rise,
  input  logic                  strobe_fall,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  frame_vld
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  vld_q, vld_d;
  logic                  shift_en;

  assign shift_en = strobe_lvl & sclk_rise & ~strobe_rise;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    vld_d = 1'b0;
    if (strobe_rise) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sh_d = {sdata_lvl, sh_q[FRAME_BITS-1:1]};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
    if (strobe_fall && cnt_q == CNT_FULL) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign frame     = sh_q;
  assign frame_vld = vld_q;

  // R2: nothing is captured while the strobe is low
  assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_lvl |=> $stable(sh_q));
  // R6: a completion is reported for one cycle per strobe fall
  assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/serial_cmd_rx_check.sv
module serial_cmd_rx_check
  import serial_cmd_rx_pkg::*;
#(
  parameter int NBYTES = FRAME_BYTES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBYTES*BYTE_W-1:0] frame,
  input  logic                     frame_vld,
  output logic                     sum_good,
  output logic                     load_init,
  output logic                     load_run,
  output logic                     reject
);
  logic [BYTE_W-1:0] acc;
  logic [HDR_W-1:0]  hdr;
  logic              hdr_init, hdr_run;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NBYTES; k++) acc = acc + frame[k*BYTE_W +: BYTE_W];
  end

  assign hdr      = frame[BYTE_W-1 -: HDR_W];
  assign hdr_init = (hdr == HDR_INIT);
  assign hdr_run  = (hdr == HDR_RUN);
  assign sum_good = (acc == '0);

  assign load_init = frame_vld & sum_good & hdr_init;
  assign load_run  = frame_vld & sum_good & hdr_run;
  assign reject    = frame_vld & ~(sum_good & (hdr_init | hdr_run));

  // R5: at most one decision per frame
  assert_decide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_init, load_run, reject}));
  // R5: every completed frame gets exactly one decision
  assert_decide_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> $countones({load_init, load_run, reject}) == 1);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                ser_data,
  input  logic                ser_strobe,
  output logic [MON_W-1:0]    mon_release,
  output logic                csum_ok,
  output logic                frame_err,
  output logic [BYTE_W-1:0]   init_start_wait,
  output logic [BYTE_W-1:0]   init_drive_wait,
  output logic [CHOP_W-1:0]   init_chop_code,
  output logic                init_osc_internal,
  output logic [MSEL_W-1:0]   init_mon_sel,
  output logic [BYTE_W-1:0]   init_iref_a,
  output logic [BYTE_W-1:0]   init_iref_b,
  output logic                a_dir,
  output logic                a_en,
  output logic [PULSE_W-1:0]  a_pulses,
  output logic [PERIOD_W-1:0] a_period,
  output logic                a_iset,
  output logic                b_dir,
  output logic                b_en,
  output logic [PULSE_W-1:0]  b_pulses,
  output logic [PERIOD_W-1:0] b_period,
  output logic                b_iset
);
  localparam int SIG_SCLK = 0;
  localparam int SIG_DATA = 1;
  localparam int SIG_STB  = 2;

  logic [2:0] s_lvl, s_rise, s_fall;
  logic [FRAME_BITS-1:0] frame;
  logic frame_vld, sum_good, load_init, load_run, reject;

  serial_cmd_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_strobe, ser_data, ser_clk}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  serial_cmd_rx_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(s_rise[SIG_SCLK]), .sdata_lvl(s_lvl[SIG_DATA]),
    .strobe_lvl(s_lvl[SIG_STB]), .strobe_rise(s_rise[SIG_STB]),
    .strobe_fall(s_fall[SIG_STB]),
    .frame(frame), .frame_vld(frame_vld)
  );

  serial_cmd_rx_check #(.NBYTES(FRAME_BYTES)) u_check (
    .clk(clk), .rst_n(rst_n),
    .frame(frame), .frame_vld(frame_vld),
    .sum_good(sum_good), .load_init(load_init),
    .load_run(load_run), .reject(reject)
  );

  // byte k of the frame (1-based)
  function automatic logic [BYTE_W-1:0] fbyte(input logic [FRAME_BITS-1:0] f, input int k);
    return f[(k-1)*BYTE_W +: BYTE_W];
  endfunction

  init_cfg_t init_q, init_d, init_dec;
  chan_cfg_t cha_q, cha_d, cha_dec;
  chan_cfg_t chb_q, chb_d, chb_dec;
  logic [MON_W-1:0] mon_q, mon_d;
  logic csum_q, csum_d, err_q, err_d;

  always_comb begin
    init_dec.start_wait   = fbyte(frame, 2);
    init_dec.drive_wait   = fbyte(frame, 3);
    init_dec.chop_code    = fbyte(frame, 4)[CHOP_W-1:0];
    init_dec.osc_internal = fbyte(frame, 4)[BYTE_W-1];
    init_dec.mon_sel      = fbyte(frame, 5)[MSEL_W-1:0];
    init_dec.iref_a       = fbyte(frame, 6);
    init_dec.iref_b       = fbyte(frame, 7);

    cha_dec.dir    = fbyte(frame, 2)[7];
    cha_dec.en     = fbyte(frame, 2)[6];
    cha_dec.pulses = fbyte(frame, 2)[PULSE_W-1:0];
    cha_dec.period = {fbyte(frame, 4)[PERIOD_W-BYTE_W-1:0], fbyte(frame, 3)};
    cha_dec.iset   = fbyte(frame, 4)[7];

    chb_dec.dir    = fbyte(frame, 5)[7];
    chb_dec.en     = fbyte(frame, 5)[6];
    chb_dec.pulses = fbyte(frame, 5)[PULSE_W-1:0];
    chb_dec.period = {fbyte(frame, 7)[PERIOD_W-BYTE_W-1:0], fbyte(frame, 6)};
    chb_dec.iset   = fbyte(frame, 7)[7];
  end

  always_comb begin
    init_d = init_q;
    cha_d  = cha_q;
    chb_d  = chb_q;
    mon_d  = mon_q;
    csum_d = csum_q;
    err_d  = 1'b0;
    if (frame_vld) begin
      csum_d = sum_good;
      err_d  = reject;
    end
    if (load_init) init_d = init_dec;
    if (load_run) begin
      cha_d = cha_dec;
      chb_d = chb_dec;
    end
    if (load_init || load_run) mon_d = fbyte(frame, 1)[MON_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      cha_q  <= '0;
      chb_q  <= '0;
      mon_q  <= '1;
      csum_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      init_q <= init_d;
      cha_q  <= cha_d;
      chb_q  <= chb_d;
      mon_q  <= mon_d;
      csum_q <= csum_d;
      err_q  <= err_d;
    end
  end

  assign mon_release       = mon_q;
  assign csum_ok           = csum_q;
  assign frame_err         = err_q;
  assign init_start_wait   = init_q.start_wait;
  assign init_drive_wait   = init_q.drive_wait;
  assign init_chop_code    = init_q.chop_code;
  assign init_osc_internal = init_q.osc_internal;
  assign init_mon_sel      = init_q.mon_sel;
  assign init_iref_a       = init_q.iref_a;
  assign init_iref_b       = init_q.iref_b;
  assign a_dir    = cha_q.dir;
  assign a_en     = cha_q.en;
  assign a_pulses = cha_q.pulses;
  assign a_period = cha_q.period;
  assign a_iset   = cha_q.iset;
  assign b_dir    = chb_q.dir;
  assign b_en     = chb_q.en;
  assign b_pulses = chb_q.pulses;
  assign b_period = chb_q.period;
  assign b_iset   = chb_q.iset;

  // R4: the status flag moves only after a completed frame
  assert_csum_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(csum_q) |-> $past(frame_vld));
  // R7: monitor controls move only after an accepted frame
  assert_mon_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mon_q) |-> $past(load_init || load_run));
  // R9: init bank moves only after an accepted init frame
  assert_init_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(init_q) |-> $past(load_init));
  // R10: channel banks move only after an accepted run-time frame
  assert_run_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cha_q) || !$stable(chb_q)) |-> $past(load_run));
  // R8: error is a single-cycle pulse
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);
  // R8: an error never comes with a bank change
  assert_err_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($stable(init_q) && $stable(cha_q) && $stable(chb_q) && $stable(mon_q)));
endmodule

// File: tb/serial_cmd_rx_bench.sv
module serial_cmd_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;

  logic [3:0] mon_release;
  logic csum_ok, frame_err;
  logic [7:0] init_start_wait, init_drive_wait, init_iref_a, init_iref_b;
  logic [4:0] init_chop_code;
  logic init_osc_internal;
  logic [6:0] init_mon_sel;
  logic a_dir, a_en, a_iset, b_dir, b_en, b_iset;
  logic [5:0] a_pulses, b_pulses;
  logic [14:0] a_period, b_period;

  always #2 clk = ~clk;

  serial_cmd_rx u_serial_cmd_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .mon_release(mon_release), .csum_ok(csum_ok), .frame_err(frame_err),
    .init_start_wait(init_start_wait), .init_drive_wait(init_drive_wait),
    .init_chop_code(init_chop_code), .init_osc_internal(init_osc_internal),
    .init_mon_sel(init_mon_sel), .init_iref_a(init_iref_a), .init_iref_b(init_iref_b),
    .a_dir(a_dir), .a_en(a_en), .a_pulses(a_pulses), .a_period(a_period), .a_iset(a_iset),
    .b_dir(b_dir), .b_en(b_en), .b_pulses(b_pulses), .b_period(b_period), .b_iset(b_iset)
  );

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  int err_exp = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n && frame_err) err_seen++;

  // expected state
  logic [3:0]  e_mon;
  logic        e_csum;
  logic [7:0]  e_sw, e_dw, e_ia, e_ib;
  logic [4:0]  e_chop;
  logic        e_osc;
  logic [6:0]  e_msel;
  logic        e_adir, e_aen, e_aiset, e_bdir, e_ben, e_biset;
  logic [5:0]  e_apul, e_bpul;
  logic [14:0] e_aper, e_bper;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R7 mon_release"}, 32'(mon_release), 32'(e_mon));
    chk({tag, " R4 csum_ok"}, 32'(csum_ok), 32'(e_csum));
    chk({tag, " R8 error pulses"}, 32'(err_seen), 32'(err_exp));
    chk({tag, " R9 init waits"}, {16'd0, init_start_wait, init_drive_wait}, {16'd0, e_sw, e_dw});
    chk({tag, " R9 init chop/osc/sel"}, {19'd0, init_chop_code, init_osc_internal, init_mon_sel},
        {19'd0, e_chop, e_osc, e_msel});
    chk({tag, " R9 init iref"}, {16'd0, init_iref_a, init_iref_b}, {16'd0, e_ia, e_ib});
    chk({tag, " R10 alpha"}, {8'd0, a_dir, a_en, a_pulses, a_period, a_iset},
        {8'd0, e_adir, e_aen, e_apul, e_aper, e_aiset});
    chk({tag, " R11 beta"}, {8'd0, b_dir, b_en, b_pulses, b_period, b_iset},
        {8'd0, e_bdir, e_ben, e_bpul, e_bper, e_biset});
  endtask

  function automatic logic [7:0] fb(input logic [63:0] f, input int k);
    return f[(k-1)*8 +: 8];
  endfunction

  function automatic logic [63:0] make_frame(input logic [2:0] hdr, input logic [3:0] mon,
                                             input logic [47:0] body, input bit good);
    logic [63:0] f;
    logic [7:0] s;
    f = '0;
    f[7:0] = {hdr, 1'b0, mon};
    f[55:8] = body;
    s = '0;
    for (int k = 1; k <= 7; k++) s = s + fb(f, k);
    f[63:56] = good ? 8'(-s) : 8'(8'(-s) + 8'd1);
    return f;
  endfunction

  task automatic model(input logic [63:0] f, input int nbits);
    logic [7:0] s;
    logic [2:0] h;
    if (nbits != 64) return;
    s = '0;
    for (int k = 1; k <= 8; k++) s = s + fb(f, k);
    h = f[7:5];
    e_csum = (s == 8'd0);
    if (s != 8'd0 || (h != 3'b111 && h != 3'b000)) begin
      err_exp++;
      return;
    end
    e_mon = f[3:0];
    if (h == 3'b111) begin
      e_sw = fb(f, 2); e_dw = fb(f, 3);
      e_chop = fb(f, 4)[4:0]; e_osc = fb(f, 4)[7];
      e_msel = fb(f, 5)[6:0]; e_ia = fb(f, 6); e_ib = fb(f, 7);
    end else begin
      e_adir = fb(f, 2)[7]; e_aen = fb(f, 2)[6]; e_apul = fb(f, 2)[5:0];
      e_aper = {fb(f, 4)[6:0], fb(f, 3)}; e_aiset = fb(f, 4)[7];
      e_bdir = fb(f, 5)[7]; e_ben = fb(f, 5)[6]; e_bpul = fb(f, 5)[5:0];
      e_bper = {fb(f, 7)[6:0], fb(f, 6)}; e_biset = fb(f, 7)[7];
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // data is flipped while the serial clock is high: only the rising edge may capture
  task automatic send_bit(input logic b);
    ser_data = b;
    wait_clk(5);
    ser_clk = 1'b1;
    wait_clk(5);
    ser_data = ~b;
    wait_clk(4);
    ser_clk = 1'b0;
    wait_clk(1);
  endtask

  task automatic send_frame(input logic [63:0] f, input int nbits);
    ser_strobe = 1'b1;
    wait_clk(5);
    for (int i = 0; i < nbits; i++) send_bit(i < 64 ? f[i] : 1'b1);
    wait_clk(3);
    ser_strobe = 1'b0;
    wait_clk(10);
    model(f, nbits);
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = 1'($urandom);
      wait_clk(5);
      ser_clk = 1'b1;
      wait_clk(5);
      ser_clk = 1'b0;
    end
    wait_clk(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] f;
    logic [2:0] hdr;
    int n;
    void'($urandom(32'd20240611));
    e_mon = 4'hF; e_csum = 1'b1;
    e_sw = '0; e_dw = '0; e_ia = '0; e_ib = '0; e_chop = '0; e_osc = 1'b0; e_msel = '0;
    e_adir = 0; e_aen = 0; e_aiset = 0; e_bdir = 0; e_ben = 0; e_biset = 0;
    e_apul = '0; e_bpul = '0; e_aper = '0; e_bper = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    check_all("R12 reset");

    // R1 R9: init frame with distinct bytes
    f = make_frame(3'b111, 4'b1010, {8'h9C, 8'h5A, 8'h35, 8'h93, 8'h12, 8'h34}, 1'b1);
    send_frame(f, 64);
    check_all("R1 init directed");
    chk("R9 start wait literal", 32'(init_start_wait), 32'h34);
    chk("R9 chop code literal", 32'(init_chop_code), 32'h13);
    chk("R9 osc select literal", 32'(init_osc_internal), 32'h1);

    // R10 R11: run frame
    f = make_frame(3'b000, 4'b0101, {8'hF1, 8'h23, 8'h7F, 8'hBE, 8'hCD, 8'h45}, 1'b1);
    send_frame(f, 64);
    check_all("R10 R11 run directed");
    chk("R10 alpha period literal", 32'(a_period), 32'h3ECD);
    chk("R11 beta period literal", 32'(b_period), 32'h7123);

    // R3 R8: bad checksum
    f = make_frame(3'b111, 4'b0000, 48'h1122_3344_5566, 1'b0);
    send_frame(f, 64);
    check_all("R3 R8 bad sum");
    chk("R4 csum low after bad sum", 32'(csum_ok), 32'h0);

    // R6: short and long frames leave the low csum flag alone
    f = make_frame(3'b000, 4'b0011, 48'hAAAA_5555_0F0F, 1'b1);
    send_frame(f, 63);
    check_all("R6 63 bits");
    send_frame(f, 65);
    check_all("R6 65 bits");

    // R2: clock activity with the strobe low
    noise(12);
    check_all("R2 idle clocks");

    // R5: good sum, illegal header
    f = make_frame(3'b010, 4'b0000, 48'h0102_0304_0506, 1'b1);
    send_frame(f, 64);
    check_all("R5 illegal header");
    chk("R5 csum high with illegal header", 32'(csum_ok), 32'h1);

    // random mix
    for (int t = 0; t < 48; t++) begin
      case ($urandom_range(0, 3))
        0: hdr = 3'b111;
        1: hdr = 3'b000;
        2: hdr = 3'($urandom_range(1, 6));
        default: hdr = ($urandom_range(0, 1) != 0) ? 3'b111 : 3'b000;
      endcase
      f = make_frame(hdr, 4'($urandom), {16'($urandom), 32'($urandom)}, $urandom_range(0, 4) != 0);
      n = 64;
      if ($urandom_range(0, 7) == 0) n = ($urandom_range(0, 1) != 0) ? 63 : 65;
      send_frame(f, n);
      check_all("R3 R5 random");
      if ($urandom_range(0, 5) == 0) begin
        noise(4);
        check_all("R2 random idle clocks");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule